// File: doc/BRIEF.md
# Host-Accessible Slave Port

This block lets an external master processor reach a small set of registers inside a microcontroller over an 8-bit asynchronous bus. The master has an active-low chip select, active-low read and write strobes, and an address-strobe pin. The master writes into a data-in register or a command register, and reads back a data-out register or a status register. The local CPU works on the other side of the block, in the system clock domain. It loads the data-out register and the user bits of the status register. It receives each master write as a one-cycle pulse, acknowledges pending commands, and raises an interrupt line toward the master.

A strap input picks how the register select is formed. In multiplexed mode the master first pulses the address strobe while bit 1 of the bus carries the select, and the falling edge of the strobe holds that bit. In demultiplexed mode the level on the address-strobe pin is the select. Select 0 addresses the data pair and select 1 addresses the command/status pair. A write commits on the rising edge of the write strobe. The captured value then crosses into the system clock through a toggle and a two-flop synchroniser.

Top module: `host_slave_port`

## Requirements
- R1: After reset, hp_bus_oe and hp_irq are 0, cpu_cmd_pend is 0, cpu_din and cpu_cmd are 0, and neither write pulse is active.
- R2: hp_bus_oe is 1 only while hp_cs_n and hp_rd_n are both low, and 0 otherwise.
- R3: A master read with select 0 drives the data-out register, last loaded by the CPU through cpu_dout_we, onto hp_bus_out. The value is valid while the read strobe is low.
- R4: A master read with select 1 drives the status byte onto hp_bus_out. Bit 0 is the command-pending flag, bit 1 is hp_irq, and bits 7:2 are the user bits last loaded through cpu_stat_we from cpu_wdata[7:2].
- R5: With hp_mux_mode = 0, the level of hp_ale during the strobe is the register select.
- R6: With hp_mux_mode = 1, the select is bus bit 1 as captured at the falling edge of hp_ale. It is held through the following data phase even when bit 1 of the bus changes.
- R7: A master write with select 0 stores the bus value, as present at the rising edge of hp_wr_n, into cpu_din. It also gives exactly one cycle of cpu_din_pulse.
- R8: A master write with select 1 stores the bus value into cpu_cmd. It gives exactly one cycle of cpu_cmd_pulse and sets cpu_cmd_pend.
- R9: Write strobes with hp_cs_n high produce no pulse and leave cpu_din and cpu_cmd unchanged.
- R10: A one-cycle cpu_cmd_ack clears cpu_cmd_pend. The flag falls only after an acknowledge.
- R11: cpu_irq_set sets hp_irq. hp_irq clears once the master completes a status read, and a data read leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_mux_mode | input | 1 | 1: multiplexed address/data, 0: demultiplexed |
| hp_cs_n | input | 1 | Master chip select, active low |
| hp_rd_n | input | 1 | Master read strobe, active low |
| hp_wr_n | input | 1 | Master write strobe, active low |
| hp_ale | input | 1 | Address strobe (mux) or live select (demux) |
| hp_bus_in | input | W | Bus value seen at the pins |
| hp_bus_out | output | W | Value driven toward the master |
| hp_bus_oe | output | 1 | Output enable for the bus drivers |
| hp_irq | output | 1 | Interrupt to the master, active high |
| cpu_wdata | input | W | CPU write data |
| cpu_dout_we | input | 1 | Load data-out register |
| cpu_stat_we | input | 1 | Load status user bits |
| cpu_irq_set | input | 1 | Raise hp_irq |
| cpu_cmd_ack | input | 1 | Clear command-pending flag |
| cpu_din | output | W | Last master data write |
| cpu_cmd | output | W | Last master command write |
| cpu_din_pulse | output | 1 | One-cycle strobe on a data write |
| cpu_cmd_pulse | output | 1 | One-cycle strobe on a command write |
| cpu_cmd_pend | output | 1 | Command waiting for acknowledge |

## Verification
The hardest case to reach from the ports is in multiplexed mode: a held select must disagree with bit 1 of the bus during the data phase that follows. The stimulus latches the select on the address strobe and then deliberately flips bus bit 1 before the strobe. A wrong decode would therefore show the other register. Interrupt clearing depends on which register the finished read addressed. Random sequences therefore interleave data reads, status reads and interrupt sets, switch modes between accesses, and throw in strobes with chip select high.

// File: rtl/host_slave_port.sv
module host_slave_port #(
  parameter int W = 8,
  parameter int SEL_BIT = 1,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hp_mux_mode,
  input  logic         hp_cs_n,
  input  logic         hp_rd_n,
  input  logic         hp_wr_n,
  input  logic         hp_ale,
  input  logic [W-1:0] hp_bus_in,
  output logic [W-1:0] hp_bus_out,
  output logic         hp_bus_oe,
  output logic         hp_irq,
  input  logic [W-1:0] cpu_wdata,
  input  logic         cpu_dout_we,
  input  logic         cpu_stat_we,
  input  logic         cpu_irq_set,
  input  logic         cpu_cmd_ack,
  output logic [W-1:0] cpu_din,
  output logic [W-1:0] cpu_cmd,
  output logic         cpu_din_pulse,
  output logic         cpu_cmd_pulse,
  output logic         cpu_cmd_pend
);
  localparam int UW = W - 2;

  logic         sel_held, sel;
  logic [W-1:0] wr_hold;
  logic         wr_sel, wr_tgl, rd_tgl;
  logic [SYNC:0] wr_sync, rd_sync;
  logic         wr_evt, rd_evt;
  logic [W-1:0] dout_q;
  logic [UW-1:0] user_q;

  always_ff @(negedge hp_ale or negedge rst_n)
    if (!rst_n) sel_held <= 1'b0;
    else        sel_held <= hp_bus_in[SEL_BIT];

  assign sel = hp_mux_mode ? sel_held : hp_ale;

  always_ff @(posedge hp_wr_n or negedge rst_n)
    if (!rst_n) begin
      wr_hold <= '0;
      wr_sel  <= 1'b0;
      wr_tgl  <= 1'b0;
    end else if (!hp_cs_n) begin
      wr_hold <= hp_bus_in;
      wr_sel  <= sel;
      wr_tgl  <= ~wr_tgl;
    end

  always_ff @(posedge hp_rd_n or negedge rst_n)
    if (!rst_n)                rd_tgl <= 1'b0;
    else if (!hp_cs_n && sel)  rd_tgl <= ~rd_tgl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_sync <= '0;
      rd_sync <= '0;
    end else begin
      wr_sync <= {wr_sync[SYNC-1:0], wr_tgl};
      rd_sync <= {rd_sync[SYNC-1:0], rd_tgl};
    end

  assign wr_evt = wr_sync[SYNC] ^ wr_sync[SYNC-1];
  assign rd_evt = rd_sync[SYNC] ^ rd_sync[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpu_din       <= '0;
      cpu_cmd       <= '0;
      cpu_din_pulse <= 1'b0;
      cpu_cmd_pulse <= 1'b0;
      cpu_cmd_pend  <= 1'b0;
      hp_irq        <= 1'b0;
      dout_q        <= '0;
      user_q        <= '0;
    end else begin
      cpu_din_pulse <= wr_evt && !wr_sel;
      cpu_cmd_pulse <= wr_evt && wr_sel;
      if (wr_evt && !wr_sel) cpu_din <= wr_hold;
      if (wr_evt && wr_sel)  cpu_cmd <= wr_hold;
      if (wr_evt && wr_sel)  cpu_cmd_pend <= 1'b1;
      else if (cpu_cmd_ack)  cpu_cmd_pend <= 1'b0;
      if (cpu_irq_set)       hp_irq <= 1'b1;
      else if (rd_evt)       hp_irq <= 1'b0;
      if (cpu_dout_we)       dout_q <= cpu_wdata;
      if (cpu_stat_we)       user_q <= cpu_wdata[W-1:2];
    end

  assign hp_bus_oe  = !hp_cs_n && !hp_rd_n;
  assign hp_bus_out = sel ? {user_q, hp_irq, cpu_cmd_pend} : dout_q;
endmodule

module host_slave_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_din_pulse,
  input logic cpu_cmd_pulse,
  input logic cpu_cmd_pend,
  input logic cpu_cmd_ack,
  input logic cpu_irq_set,
  input logic hp_irq
);
  // R7
  din_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_din_pulse |=> !cpu_din_pulse);
  // R8
  cmd_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cmd_pulse |=> !cpu_cmd_pulse);
  // R8
  cmd_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cmd_pulse |-> cpu_cmd_pend);
  // R7
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_din_pulse && cpu_cmd_pulse));
  // R10
  pend_falls_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_cmd_pend) |-> $past(cpu_cmd_ack));
  // R11
  irq_rises_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hp_irq) |-> $past(cpu_irq_set));
endmodule

bind host_slave_port host_slave_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_din_pulse(cpu_din_pulse),
  .cpu_cmd_pulse(cpu_cmd_pulse), .cpu_cmd_pend(cpu_cmd_pend),
  .cpu_cmd_ack(cpu_cmd_ack), .cpu_irq_set(cpu_irq_set), .hp_irq(hp_irq)
);

// File: tb/test_host_slave_port.sv
module test_host_slave_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic hp_mux_mode = 0, hp_cs_n = 1, hp_rd_n = 1, hp_wr_n = 1, hp_ale = 0;
  logic [W-1:0] hp_bus_in = '0, hp_bus_out, cpu_wdata = '0, cpu_din, cpu_cmd;
  logic hp_bus_oe, hp_irq, cpu_dout_we = 0, cpu_stat_we = 0, cpu_irq_set = 0, cpu_cmd_ack = 0;
  logic cpu_din_pulse, cpu_cmd_pulse, cpu_cmd_pend;

  int checks = 0, errors = 0, n_din = 0, n_cmd = 0;
  logic [W-1:0] e_din = 0, e_cmd = 0, e_dout = 0;
  logic [5:0] e_user = 0;
  logic e_pend = 0, e_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_slave_port i_host_slave_port (.*);

  always @(negedge clk) begin
    if (cpu_din_pulse) n_din++;
    if (cpu_cmd_pulse) n_cmd++;
  end

  function automatic logic [W-1:0] stat_exp();
    return {e_user, e_irq, e_pend};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(); repeat (6) @(negedge clk); endtask

  task automatic address(logic s);
    if (hp_mux_mode) begin
      hp_bus_in = W'($urandom) ^ W'(((W'($urandom) >> 1) & 1) << 1);
      hp_bus_in[1] = s;
      hp_ale = 1; @(negedge clk);
      hp_ale = 0; #1;
      hp_bus_in[1] = ~s;
    end else hp_ale = s;
  endtask

  task automatic host_write(logic s, logic [W-1:0] v, logic cs = 1);
    int d0 = n_din, c0 = n_cmd;
    @(negedge clk); address(s);
    hp_bus_in = v; hp_cs_n = !cs; hp_wr_n = 0;
    @(negedge clk); hp_wr_n = 1;
    #2 hp_cs_n = 1; hp_ale = 0;
    settle();
    if (cs && !s) e_din = v;
    if (cs && s) begin e_cmd = v; e_pend = 1; end
    if (!cs) begin
      chk("R9 din", cpu_din, e_din); chk("R9 cmd", cpu_cmd, e_cmd);
      chk("R9 pulses", n_din + n_cmd, d0 + c0);
    end else if (!s) begin
      chk("R7 din", cpu_din, e_din); chk("R7 pulse", n_din, d0 + 1);
    end else begin
      chk("R8 cmd", cpu_cmd, e_cmd); chk("R8 pulse", n_cmd, c0 + 1);
      chk("R8 pend", cpu_cmd_pend, 1);
    end
  endtask

  task automatic host_read(logic s);
    @(negedge clk); address(s);
    hp_cs_n = 0; hp_rd_n = 0; #1;
    chk("R2 oe during read", hp_bus_oe, 1);
    if (s) chk(hp_mux_mode ? "R6/R4 status" : "R5/R4 status", hp_bus_out, stat_exp());
    else   chk(hp_mux_mode ? "R6/R3 data" : "R5/R3 data", hp_bus_out, e_dout);
    @(negedge clk); hp_rd_n = 1;
    #2 hp_cs_n = 1; hp_ale = 0;
    settle();
    if (s) e_irq = 0;
    chk("R11 irq after read", hp_irq, e_irq);
  endtask

  task automatic cpu_pulse(int which, logic [W-1:0] v);
    @(negedge clk);
    cpu_wdata = v;
    case (which)
      0: cpu_dout_we = 1;
      1: cpu_stat_we = 1;
      2: cpu_irq_set = 1;
      default: cpu_cmd_ack = 1;
    endcase
    @(negedge clk);
    {cpu_dout_we, cpu_stat_we, cpu_irq_set, cpu_cmd_ack} = '0;
    case (which)
      0: e_dout = v;
      1: e_user = v[7:2];
      2: begin e_irq = 1; chk("R11 irq set", hp_irq, 1); end
      default: begin e_pend = 0; chk("R10 ack clears", cpu_cmd_pend, 0); end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 oe", hp_bus_oe, 0); chk("R1 irq", hp_irq, 0);
    chk("R1 pend", cpu_cmd_pend, 0); chk("R1 din", cpu_din, 0);
    chk("R1 cmd", cpu_cmd, 0); chk("R1 pulses", {cpu_din_pulse, cpu_cmd_pulse}, 0);
    rst_n = 1; settle();

    hp_rd_n = 0; #1; chk("R2 oe cs high", hp_bus_oe, 0);
    hp_rd_n = 1; hp_cs_n = 0; #1; chk("R2 oe rd high", hp_bus_oe, 0);
    hp_cs_n = 1;

    cpu_pulse(0, 8'hA5); cpu_pulse(1, 8'hFC);
    hp_mux_mode = 0;
    host_write(0, 8'h3C); host_write(1, 8'h81);
    host_read(0); host_read(1);
    hp_mux_mode = 1;
    host_write(0, 8'hC3); host_write(1, 8'h42);
    host_read(0); host_read(1);
    host_write(0, 8'h11, 0); host_write(1, 8'h22, 0);
    cpu_pulse(3, 0);
    cpu_pulse(2, 0); host_read(0); host_read(1);

    for (int i = 0; i < 300; i++) begin
      int op = $urandom % 7;
      hp_mux_mode = $urandom % 2;
      case (op)
        0: host_write(0, W'($urandom));
        1: host_write(1, W'($urandom));
        2: host_read(0);
        3: host_read(1);
        4: cpu_pulse($urandom % 2, W'($urandom));
        5: cpu_pulse(2 + ($urandom % 2), 0);
        default: host_write($urandom % 2, W'($urandom), 0);
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule